// File: doc/BRIEF.md
# Reset Cause Controller

This block collects reset requests from the hardware sources around a small processor system, decides which of them may reset it, drives the system reset, and keeps an 8-bit record of what caused the most recent reset. The sources are an external reset pin, a supply-monitor trip, a watchdog expiry, a lost-clock detection, an active-low comparator level, a real-time-clock alarm or oscillator-fail event, a flash access error, and a software request made through the register port.

Four of the register's bits serve two purposes. A write to them stores an enable that decides whether that source may reset the system. A normal read returns the cause flag instead. A read marked as the first half of a read-modify-write returns the stored enables, so a masked update does not copy cause flags into the enables. Writing 1 to the software bit resets the system. Each reset holds the reset output for a fixed number of cycles. When several requests arrive in the same cycle, a fixed priority chooses the one that is recorded.

Top module: `rstcause_ctrl`

## Requirements
- R1: The cause word has this layout: bit 7 clock-alarm, bit 6 flash error, bit 5 comparator, bit 4 software, bit 3 watchdog, bit 2 lost clock, bit 1 power-on/supply, bit 0 pin. Exactly one bit is set at all times. A normal read (`reg_sel`, `reg_re`, `reg_rmw`=0) returns it on `reg_rdata` one clock later.
- R2: While `por_n` is low, `sys_rst` is asserted, the cause word is 0x02 and all enables are 0. This holds no matter what the earlier state was.
- R3: A pin, watchdog or flash request always resets the system. It records 0x01, 0x08 or 0x40.
- R4: A lost-clock (enable at bit 2), clock-alarm (bit 7) or supply-monitor (bit 1) request resets the system only when its enable is 1. It then records 0x04, 0x80 or 0x02. When the enable is 0, the request has no effect.
- R5: When the comparator enable (bit 5) is 1, a low `cmp_out` resets the system and records 0x20. A high level never does. When the enable is 0, a low level has no effect.
- R6: A write with bit 4 set resets the system and records 0x10. A write with bit 4 clear never resets the system.
- R7: Among simultaneous requests, the one recorded wins in this order: supply, pin, lost clock, watchdog, software, comparator, clock-alarm, flash.
- R8: Every reset holds `sys_rst` high for exactly RST_CYCLES (16) clocks. It starts with the clock edge that samples the request, or with the release of `por_n`.
- R9: A read with `reg_rmw`=1 returns the enables in bits 7, 5, 2 and 1, with 0 in every other bit.
- R10: While `sys_rst` is high, requests and register writes are ignored. Enables keep their values across every reset other than power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_rst | input | 1 | External reset pin request |
| sup_mon_trip | input | 1 | Supply monitor trip |
| clk_missing | input | 1 | Lost-clock detection |
| wdt_expire | input | 1 | Watchdog expiry |
| cmp_out | input | 1 | Comparator level, a low level requests reset |
| rtc_event | input | 1 | Clock alarm or oscillator fail |
| flash_err | input | 1 | Flash access error |
| reg_sel | input | 1 | Register select |
| reg_we | input | 1 | Write enable |
| reg_re | input | 1 | Read enable |
| reg_rmw | input | 1 | Read is the first half of a read-modify-write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| sys_rst | output | 1 | System reset |

## Verification
Each source is fired alone, so that every cause lands in its own bit position. The gated sources are fired once with their enable clear and once with it set, which separates gating from recording. Groups of sources are fired in the same cycle to confirm the winner order. Further tests fire requests and writes while a reset is in progress, compare normal reads with read-modify-write reads, and repeat the power-on reset in mid-run, which tells enable storage apart from flag storage.

// File: rtl/rstc_pkg.sv
`timescale 1ns/1ps
package rstc_pkg;

    localparam int CAUSE_W = 8;
    localparam int NSRC    = 8;

    localparam int B_PIN   = 0;
    localparam int B_POR   = 1;
    localparam int B_MCD   = 2;
    localparam int B_WDT   = 3;
    localparam int B_SW    = 4;
    localparam int B_CMP   = 5;
    localparam int B_FLASH = 6;
    localparam int B_RTC   = 7;

    // Rank 0 is the highest priority.
    localparam int PRIO_ORDER [NSRC] = '{B_POR, B_PIN, B_MCD, B_WDT, B_SW, B_CMP, B_RTC, B_FLASH};

    localparam logic [CAUSE_W-1:0] POR_CAUSE = CAUSE_W'(1) << B_POR;

    typedef struct packed {
        logic rtc_en;
        logic cmp_en;
        logic mcd_en;
        logic vmon_en;
    } en_t;

    typedef struct packed {
        en_t                en;
        logic [CAUSE_W-1:0] flags;
        logic [CAUSE_W-1:0] rdata;
    } ctl_state_t;

    function automatic en_t en_from_word(input logic [CAUSE_W-1:0] w);
        en_t e;
        e.rtc_en  = w[B_RTC];
        e.cmp_en  = w[B_CMP];
        e.mcd_en  = w[B_MCD];
        e.vmon_en = w[B_POR];
        return e;
    endfunction

    function automatic logic [CAUSE_W-1:0] en_to_word(input en_t e);
        logic [CAUSE_W-1:0] w;
        w        = '0;
        w[B_RTC] = e.rtc_en;
        w[B_CMP] = e.cmp_en;
        w[B_MCD] = e.mcd_en;
        w[B_POR] = e.vmon_en;
        return w;
    endfunction

endpackage

// File: rtl/rstc_gate.sv
`timescale 1ns/1ps
module rstc_gate
    import rstc_pkg::*;
(
    input  logic               pin_req,
    input  logic               sup_trip,
    input  logic               clk_lost,
    input  logic               wdt_req,
    input  logic               sw_req,
    input  logic               cmp_level,
    input  logic               rtc_req,
    input  logic               flash_req,
    input  en_t                en,
    output logic [CAUSE_W-1:0] req
);

    always_comb begin
        req          = '0;
        req[B_PIN]   = pin_req;
        req[B_POR]   = sup_trip & en.vmon_en;
        req[B_MCD]   = clk_lost & en.mcd_en;
        req[B_WDT]   = wdt_req;
        req[B_SW]    = sw_req;
        req[B_CMP]   = ~cmp_level & en.cmp_en;   // low level requests reset
        req[B_RTC]   = rtc_req & en.rtc_en;
        req[B_FLASH] = flash_req;
    end

endmodule

// File: rtl/rstc_arbiter.sv
`timescale 1ns/1ps
module rstc_arbiter
    import rstc_pkg::*;
(
    input  logic [CAUSE_W-1:0] req,
    output logic [CAUSE_W-1:0] grant,
    output logic               hit
);

    logic [NSRC:0]   taken;
    logic [NSRC-1:0] grant_rank;

    assign taken[0] = 1'b0;

    for (genvar k = 0; k < NSRC; k++) begin : g_rank
        assign grant_rank[k] = req[PRIO_ORDER[k]] & ~taken[k];
        assign taken[k+1]    = taken[k] | req[PRIO_ORDER[k]];
    end

    always_comb begin
        grant = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (grant_rank[k]) grant[PRIO_ORDER[k]] = 1'b1;
        end
    end

    assign hit = taken[NSRC];

endmodule

// File: rtl/rstc_stretch.sv
`timescale 1ns/1ps
module rstc_stretch #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic trigger,
    output logic active
);

    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } str_state_t;

    str_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.cnt == '0) st_d.active = 1'b0;
            else                st_d.cnt    = st_q.cnt - 1'b1;
        end else if (trigger) begin
            st_d.active = 1'b1;
            st_d.cnt    = CW'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.active <= 1'b1;
            st_q.cnt    <= CW'(CYCLES - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;

endmodule

// File: rtl/rstcause_ctrl.sv
`timescale 1ns/1ps
module rstcause_ctrl
    import rstc_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               pin_rst,
    input  logic               sup_mon_trip,
    input  logic               clk_missing,
    input  logic               wdt_expire,
    input  logic               cmp_out,
    input  logic               rtc_event,
    input  logic               flash_err,
    input  logic               reg_sel,
    input  logic               reg_we,
    input  logic               reg_re,
    input  logic               reg_rmw,
    input  logic [CAUSE_W-1:0] reg_wdata,
    output logic [CAUSE_W-1:0] reg_rdata,
    output logic               sys_rst
);

    ctl_state_t         state_d, state_q;
    logic [CAUSE_W-1:0] req, grant;
    logic               hit, wr_acc, rd_acc, idle, sw_req, trigger;
    logic [CAUSE_W-1:0] flags_w;
    logic [3:0]         en_w;

    assign wr_acc  = reg_sel & reg_we;
    assign rd_acc  = reg_sel & reg_re;
    assign idle    = ~sys_rst;
    assign sw_req  = wr_acc & reg_wdata[B_SW];
    assign trigger = idle & hit;

    rstc_gate u_gate (
        .pin_req   (pin_rst),
        .sup_trip  (sup_mon_trip),
        .clk_lost  (clk_missing),
        .wdt_req   (wdt_expire),
        .sw_req    (sw_req),
        .cmp_level (cmp_out),
        .rtc_req   (rtc_event),
        .flash_req (flash_err),
        .en        (state_q.en),
        .req       (req)
    );

    rstc_arbiter u_arb (
        .req   (req),
        .grant (grant),
        .hit   (hit)
    );

    rstc_stretch #(.CYCLES(RST_CYCLES)) u_stretch (
        .clk     (clk),
        .por_n   (por_n),
        .trigger (trigger),
        .active  (sys_rst)
    );

    always_comb begin
        state_d = state_q;
        if (idle) begin
            if (wr_acc) state_d.en    = en_from_word(reg_wdata);
            if (hit)    state_d.flags = grant;
        end
        if (rd_acc) begin
            state_d.rdata = reg_rmw ? en_to_word(state_q.en) : state_q.flags;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q.en    <= '0;
            state_q.flags <= POR_CAUSE;
            state_q.rdata <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign reg_rdata = state_q.rdata;
    assign flags_w   = state_q.flags;
    assign en_w      = state_q.en;

endmodule

// File: rtl/rstc_checker.sv
`timescale 1ns/1ps
module rstc_checker
    import rstc_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input logic               clk,
    input logic               por_n,
    input logic               sys_rst,
    input logic               pin_rst,
    input logic               sup_mon_trip,
    input logic               reg_sel,
    input logic               reg_we,
    input logic [CAUSE_W-1:0] reg_wdata,
    input logic [CAUSE_W-1:0] flags,
    input logic [3:0]         en
);

    localparam int RW = $clog2(RST_CYCLES + 2);
    logic [RW-1:0] run;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                         run <= '0;
        else if (!sys_rst)                  run <= '0;
        else if (run != RW'(RST_CYCLES + 1)) run <= run + 1'b1;
    end

    a_r1_one_cause: assert property (@(posedge clk) disable iff (!por_n)
        $countones(flags) == 1);

    a_r6_sw_forces: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst && reg_sel && reg_we && reg_wdata[B_SW]) |=> sys_rst);

    a_r7_pin_wins: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst && pin_rst && !(sup_mon_trip && en[0])) |=> (sys_rst && flags[B_PIN]));

    a_r8_stretch_len: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst) |-> (run == RW'(RST_CYCLES)));

    a_r8_no_overrun: assert property (@(posedge clk) disable iff (!por_n)
        run <= RW'(RST_CYCLES));

    a_r10_en_hold: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> $stable(en));

endmodule

bind rstcause_ctrl rstc_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .sys_rst      (sys_rst),
    .pin_rst      (pin_rst),
    .sup_mon_trip (sup_mon_trip),
    .reg_sel      (reg_sel),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .flags        (flags_w),
    .en           (en_w)
);

// File: tb/tb_rstcause_ctrl.sv
`timescale 1ns/1ps
module tb_rstcause_ctrl;

    localparam int RST_CYCLES = 16;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       pin_rst = 0, sup_mon_trip = 0, clk_missing = 0, wdt_expire = 0;
    logic       cmp_out = 1, rtc_event = 0, flash_err = 0;
    logic       reg_sel = 0, reg_we = 0, reg_re = 0, reg_rmw = 0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sys_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    rstcause_ctrl #(.RST_CYCLES(RST_CYCLES)) dut (
        .clk(clk), .por_n(por_n), .pin_rst(pin_rst), .sup_mon_trip(sup_mon_trip),
        .clk_missing(clk_missing), .wdt_expire(wdt_expire), .cmp_out(cmp_out),
        .rtc_event(rtc_event), .flash_err(flash_err), .reg_sel(reg_sel),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rmw(reg_rmw),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst(sys_rst)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input bit rmw, output logic [7:0] v);
        @(negedge clk); reg_sel = 1; reg_re = 1; reg_rmw = rmw;
        @(negedge clk); reg_sel = 0; reg_re = 0; reg_rmw = 0;
        v = reg_rdata;
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk); reg_sel = 1; reg_we = 1; reg_wdata = v;
        @(negedge clk); reg_sel = 0; reg_we = 0; reg_wdata = '0;
    endtask

    // mask: 0 pin,1 supply,2 lost clock,3 watchdog,5 comparator low,6 flash,7 alarm
    task automatic fire(input logic [7:0] m);
        @(negedge clk);
        pin_rst = m[0]; sup_mon_trip = m[1]; clk_missing = m[2]; wdt_expire = m[3];
        cmp_out = ~m[5]; flash_err = m[6]; rtc_event = m[7];
        @(negedge clk);
        pin_rst = 0; sup_mon_trip = 0; clk_missing = 0; wdt_expire = 0;
        cmp_out = 1; flash_err = 0; rtc_event = 0;
    endtask

    task automatic measure_rst(output int n);
        n = 0;
        while (sys_rst && n < 100) begin n++; @(negedge clk); end
    endtask

    task automatic expect_reset(input string tag, input logic [7:0] exp);
        int n;
        logic [7:0] v;
        check({tag, " reset taken"}, sys_rst, 1);
        measure_rst(n);
        check("R8 stretch length", n, RST_CYCLES);
        read_reg(0, v);
        check({tag, " cause"}, v, exp);
    endtask

    task automatic expect_quiet(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        check({tag, " no reset"}, sys_rst, 0);
        read_reg(0, v);
        check({tag, " cause kept"}, v, exp);
    endtask

    task automatic t_power_on;
        int n;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        check("R2 reset held", sys_rst, 1);
        por_n = 1;
        measure_rst(n);
        check("R8 stretch after power-on", n, RST_CYCLES);
        read_reg(0, v); check("R2 cause after power-on", v, 8'h02);
        read_reg(1, v); check("R2 enables cleared", v, 8'h00);
    endtask

    task automatic t_always_on;
        fire(8'h01); expect_reset("R3 pin", 8'h01);
        fire(8'h08); expect_reset("R3 watchdog", 8'h08);
        fire(8'h40); expect_reset("R3 flash", 8'h40);
    endtask

    task automatic t_gated;
        logic [7:0] v;
        fire(8'h04); expect_quiet("R4 lost clock disabled", 8'h40);
        fire(8'h80); expect_quiet("R4 alarm disabled", 8'h40);
        fire(8'h02); expect_quiet("R4 supply disabled", 8'h40);
        write_reg(8'hA6);
        check("R6 zero bit no reset", sys_rst, 0);
        read_reg(1, v); check("R9 enables via rmw read", v, 8'hA6);
        fire(8'h04); expect_reset("R4 lost clock", 8'h04);
        fire(8'h80); expect_reset("R4 alarm", 8'h80);
        fire(8'h02); expect_reset("R4 supply", 8'h02);
        read_reg(1, v); check("R10 enables survive reset", v, 8'hA6);
    endtask

    task automatic t_comparator;
        @(negedge clk); cmp_out = 1;
        @(negedge clk); expect_quiet("R5 high level", 8'h02);
        fire(8'h20); expect_reset("R5 low level", 8'h20);
        write_reg(8'h86);
        fire(8'h20); expect_quiet("R5 disabled", 8'h20);
    endtask

    task automatic t_software;
        logic [7:0] v;
        write_reg(8'h96);
        expect_reset("R6 forced", 8'h10);
        read_reg(1, v); check("R9 rmw hides flags", v, 8'h86);
        write_reg(8'h86);
        expect_quiet("R6 bit clear", 8'h10);
    endtask

    task automatic t_priority;
        fire(8'h49); expect_reset("R7 pin over watchdog/flash", 8'h01);
        fire(8'h0C); expect_reset("R7 lost clock over watchdog", 8'h04);
        fire(8'h03); expect_reset("R7 supply over pin", 8'h02);
        fire(8'h48); expect_reset("R7 watchdog over flash", 8'h08);
        fire(8'hC0); expect_reset("R7 alarm over flash", 8'h80);
        @(negedge clk); wdt_expire = 1; reg_sel = 1; reg_we = 1; reg_wdata = 8'h96;
        @(negedge clk); wdt_expire = 0; reg_sel = 0; reg_we = 0; reg_wdata = 0;
        expect_reset("R7 watchdog over software", 8'h08);
    endtask

    task automatic t_busy;
        int n;
        logic [7:0] v;
        fire(8'h01);
        check("R10 reset running", sys_rst, 1);
        @(negedge clk); flash_err = 1; reg_sel = 1; reg_we = 1; reg_wdata = 8'h10;
        @(negedge clk); flash_err = 0; reg_sel = 0; reg_we = 0; reg_wdata = 0;
        measure_rst(n);
        check("R8 stretch not extended", n, RST_CYCLES - 2);
        repeat (2) @(negedge clk);
        check("R10 no retrigger", sys_rst, 0);
        read_reg(0, v); check("R10 request ignored in reset", v, 8'h01);
        read_reg(1, v); check("R10 write ignored in reset", v, 8'h86);
    endtask

    task automatic t_power_again;
        int n;
        logic [7:0] v;
        @(negedge clk); por_n = 0;
        @(negedge clk); @(negedge clk); por_n = 1;
        measure_rst(n);
        check("R8 stretch after second power-on", n, RST_CYCLES);
        read_reg(0, v); check("R1 cause after power-on", v, 8'h02);
        read_reg(1, v); check("R2 enables cleared again", v, 8'h00);
    endtask

    initial begin
        t_power_on();
        t_always_on();
        t_gated();
        t_comparator();
        t_software();
        t_priority();
        t_busy();
        t_power_again();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule